// File: doc/BRIEF.md
# SPI Status and Fault Flag Unit

This block sits beside an 8-bit serial shift engine that can run as bus master or as slave. It holds the flags that report what the engine has done: a receive-full flag, an overflow flag and a mode-fault flag. It also holds the received-data register and a small control register. A processor reaches it through a simple register port. The control register selects master or slave operation, and from that the block drives the direction controls for the clock, master-out and master-in pins.

The flags clear only through a fixed two-step access. The processor first reads the status register while a flag is set, then reads the data register (for receive-full and overflow) or writes the control register (for mode fault). The status read arms each flag that was set at that moment. The second access clears only the armed flags, so a flag that rises between the two accesses survives. When a byte arrives while the previous one is still unread, the new byte is dropped and the overflow flag is raised.

A mode fault means the slave-select pin disagrees with the chosen role. It can be raised only while the fault-enable bit is 1. Turning that bit off leaves a flag that is already set as it is.

Top module: `spi_flag_unit`

## Requirements
- R1: Register port, 2-bit address: 0 reads status (bit 0 receive-full, bit 1 overflow, bit 2 mode fault, other bits 0); 1 reads the received-data register; 2 writes or reads control (bit 0 master select, bit 1 fault enable, other bits read 0).
- R2: With master select 1, `sck_oe` and `mosi_oe` are 1 and `miso_oe` is 0; with master select 0 the three values are inverted.
- R3: A receive strobe while receive-full is 0 sets receive-full and loads the byte into the data register on that clock edge.
- R4: A receive strobe while receive-full is 1 sets overflow, drops the new byte, and keeps the unread byte in the data register.
- R5: Receive-full clears on a data read only when the most recent status read saw it set; a data read with no such arming leaves it set.
- R6: Overflow clears on a data read only when the most recent status read saw it set.
- R7: A flag that becomes set after the arming status read is not cleared by the following data read or control write.
- R8: In slave mode with fault enable 1, the slave-select pin high while a transfer is active sets mode fault; the pin high with no transfer, or low during a transfer, does not.
- R9: In master mode with fault enable 1, the slave-select pin low sets mode fault.
- R10: Mode fault never sets while fault enable is 0; clearing fault enable does not clear a mode fault that is already set.
- R11: Mode fault clears on a control write only when the most recent status read saw it set.
- R12: After reset all flags, the data register and the control register are 0, which puts the block in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ss_level | input | 1 | Slave-select pin level |
| xfer_active | input | 1 | Shift engine is mid-transfer |
| rx_done | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | 8 | The received byte, valid with `rx_done` |
| sck_oe | output | 1 | Serial clock pin drive enable |
| mosi_oe | output | 1 | Master-out pin drive enable |
| miso_oe | output | 1 | Master-in pin drive enable |
| rx_full | output | 1 | Receive-full flag |
| overflow | output | 1 | Overflow flag |
| mode_fault | output | 1 | Mode-fault flag |
| rx_data | output | 8 | Received-data register |

## Verification
The hardest case to produce is a flag that rises in the gap between the arming status read and the clearing access. From the ports this looks the same as an ordinary clear. The stimulus table therefore places a receive strobe between a status read, taken while only receive-full is set, and the next data read. It then reads status again and expects overflow alone to remain. Mode fault follows the same pattern: the fault is raised after a status read that saw it clear, and a control write that disables the fault checking must leave the flag set.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_DATA   = 2'd1,
    REG_CTRL   = 2'd2
  } reg_sel_e;

  localparam int ST_FULL   = 0;
  localparam int ST_OVF    = 1;
  localparam int ST_FAULT  = 2;
  localparam int CT_MASTER = 0;
  localparam int CT_FEN    = 1;

  // Role conflict on the select pin: a master sees it driven low,
  // a slave sees it released high in the middle of a transfer.
  function automatic logic role_conflict(logic master, logic ss, logic active);
    return master ? ~ss : (ss & active);
  endfunction

  function automatic logic [7:0] status_word(logic full, logic ovf, logic flt);
    logic [7:0] w;
    w = '0;
    w[ST_FULL]  = full;
    w[ST_OVF]   = ovf;
    w[ST_FAULT] = flt;
    return w;
  endfunction
endpackage

// File: rtl/sfu_ctrl_reg.sv
module sfu_ctrl_reg
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              master,
  output logic              fault_en,
  output logic              sck_oe,
  output logic              mosi_oe,
  output logic              miso_oe
);
  localparam int PIN_N = 3;

  wire unused_wdata_hi = ^wdata[DATA_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master   <= 1'b0;
      fault_en <= 1'b0;
    end else if (wr_en) begin
      master   <= wdata[CT_MASTER];
      fault_en <= wdata[CT_FEN];
    end
  end

  // index 0: clock, 1: master-out, 2: master-in (driven only as slave)
  logic [PIN_N-1:0] oe;
  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    if (p == PIN_N - 1) begin : g_in
      assign oe[p] = ~master;
    end else begin : g_out
      assign oe[p] = master;
    end
  end

  assign sck_oe  = oe[0];
  assign mosi_oe = oe[1];
  assign miso_oe = oe[2];
endmodule

// File: rtl/sfu_rx_flags.sv
module sfu_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic              rx_full,
  output logic              overflow,
  output logic [DATA_W-1:0] rx_data,
  output logic              ev_load,
  output logic              ev_ovf
);
  logic arm_full, arm_ovf;
  logic clr_full, clr_ovf;

  assign ev_load  = rx_done & ~rx_full;
  assign ev_ovf   = rx_done & rx_full;
  assign clr_full = data_rd & arm_full;
  assign clr_ovf  = data_rd & arm_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_full <= 1'b0;
      arm_ovf  <= 1'b0;
    end else if (stat_rd) begin
      arm_full <= rx_full;
      arm_ovf  <= overflow;
    end else if (data_rd) begin
      arm_full <= 1'b0;
      arm_ovf  <= 1'b0;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full  <= 1'b0;
      overflow <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_done)       rx_full <= 1'b1;
      else if (clr_full) rx_full <= 1'b0;
      if (ev_ovf)        overflow <= 1'b1;
      else if (clr_ovf)  overflow <= 1'b0;
      if (ev_load)       rx_data <= rx_byte;
    end
  end
endmodule

// File: rtl/sfu_fault_flag.sv
module sfu_fault_flag
  import spi_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic fault_en,
  input  logic ss_level,
  input  logic xfer_active,
  input  logic stat_rd,
  input  logic ctrl_wr,
  output logic mode_fault,
  output logic ev_fault
);
  logic arm_flt;

  assign ev_fault = fault_en & role_conflict(master, ss_level, xfer_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_flt    <= 1'b0;
      mode_fault <= 1'b0;
    end else begin
      if (stat_rd)      arm_flt <= mode_fault;
      else if (ctrl_wr) arm_flt <= 1'b0;
      if (ev_fault)                mode_fault <= 1'b1;
      else if (ctrl_wr && arm_flt) mode_fault <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ss_level,
  input  logic              xfer_active,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              sck_oe,
  output logic              mosi_oe,
  output logic              miso_oe,
  output logic              rx_full,
  output logic              overflow,
  output logic              mode_fault,
  output logic [DATA_W-1:0] rx_data
);
  logic ctl_master, ctl_fault_en;
  logic ev_stat_rd, ev_data_rd, ev_ctrl_wr;
  logic ev_rx_load, ev_rx_ovf, ev_fault_set;

  assign ev_stat_rd = bus_sel & ~bus_wr & (bus_addr == REG_STATUS);
  assign ev_data_rd = bus_sel & ~bus_wr & (bus_addr == REG_DATA);
  assign ev_ctrl_wr = bus_sel &  bus_wr & (bus_addr == REG_CTRL);

  sfu_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_ctrl_wr), .wdata(bus_wdata),
    .master(ctl_master), .fault_en(ctl_fault_en),
    .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe)
  );

  sfu_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .stat_rd(ev_stat_rd), .data_rd(ev_data_rd),
    .rx_full(rx_full), .overflow(overflow), .rx_data(rx_data),
    .ev_load(ev_rx_load), .ev_ovf(ev_rx_ovf)
  );

  sfu_fault_flag u_flt (
    .clk(clk), .rst_n(rst_n), .master(ctl_master), .fault_en(ctl_fault_en),
    .ss_level(ss_level), .xfer_active(xfer_active),
    .stat_rd(ev_stat_rd), .ctrl_wr(ev_ctrl_wr),
    .mode_fault(mode_fault), .ev_fault(ev_fault_set)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_STATUS: bus_rdata = DATA_W'(status_word(rx_full, overflow, mode_fault));
      REG_DATA:   bus_rdata = rx_data;
      REG_CTRL: begin
        bus_rdata[CT_MASTER] = ctl_master;
        bus_rdata[CT_FEN]    = ctl_fault_en;
      end
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_flag_unit_chk.sv
module sfu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_master,
  input logic              ctl_fault_en,
  input logic              ev_ctrl_wr,
  input logic              ev_data_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ss_level,
  input logic              xfer_active,
  input logic              rx_done,
  input logic [DATA_W-1:0] rx_byte,
  input logic              sck_oe,
  input logic              miso_oe,
  input logic              rx_full,
  input logic              overflow,
  input logic              mode_fault,
  input logic [DATA_W-1:0] rx_data
);
  AST_MASTER_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_wr && bus_wdata[0] |=> sck_oe && !miso_oe); // R2
  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_full |=> rx_full && rx_data == $past(rx_byte)); // R3
  AST_OVF_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full |=> overflow && $stable(rx_data)); // R4
  AST_FULL_CLR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(ev_data_rd)); // R5
  AST_OVF_CLR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overflow) |-> $past(ev_data_rd)); // R6
  AST_SLAVE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fault_en && !ctl_master && ss_level && xfer_active |=> mode_fault); // R8
  AST_MASTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fault_en && ctl_master && !ss_level |=> mode_fault); // R9
  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_fault_en && !mode_fault |=> !mode_fault); // R10
  AST_FAULT_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_fault) |-> $past(ev_ctrl_wr)); // R11
endmodule

bind spi_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_master(ctl_master), .ctl_fault_en(ctl_fault_en),
  .ev_ctrl_wr(ev_ctrl_wr), .ev_data_rd(ev_data_rd), .bus_wdata(bus_wdata),
  .ss_level(ss_level), .xfer_active(xfer_active), .rx_done(rx_done),
  .rx_byte(rx_byte), .sck_oe(sck_oe), .miso_oe(miso_oe), .rx_full(rx_full),
  .overflow(overflow), .mode_fault(mode_fault), .rx_data(rx_data)
);

// File: tb/sim_spi_flag_unit.sv
`timescale 1ns/100ps
module sim_spi_flag_unit;
  localparam int W = 8;
  // opcodes
  localparam logic [2:0] OP_IDLE = 3'd0, OP_RX = 3'd1, OP_SR = 3'd2,
                         OP_DR = 3'd3, OP_CW = 3'd4, OP_CR = 3'd5;
  localparam int N = 41;
  // {op, ss, active, arg, expected}
  localparam logic [20:0] VEC [N] = '{
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R12 status zero
    {OP_CR,  1'b1,1'b0,8'h00,8'h00}, // R12 control zero
    {OP_DR,  1'b1,1'b0,8'h00,8'h00}, // R12 data zero
    {OP_RX,  1'b1,1'b0,8'hA5,8'h00},
    {OP_SR,  1'b1,1'b0,8'h00,8'h01}, // R3 R1
    {OP_DR,  1'b1,1'b0,8'h00,8'hA5}, // R3
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R5 cleared
    {OP_RX,  1'b1,1'b0,8'h3C,8'h00},
    {OP_DR,  1'b1,1'b0,8'h00,8'h3C}, // R5 unarmed read
    {OP_SR,  1'b1,1'b0,8'h00,8'h01}, // R5 still full
    {OP_RX,  1'b1,1'b0,8'h77,8'h00}, // R4
    {OP_SR,  1'b1,1'b0,8'h00,8'h03}, // R4
    {OP_DR,  1'b1,1'b0,8'h00,8'h3C}, // R4 old byte kept
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R6 R5
    {OP_RX,  1'b1,1'b0,8'h11,8'h00},
    {OP_SR,  1'b1,1'b0,8'h00,8'h01},
    {OP_RX,  1'b1,1'b0,8'h22,8'h00}, // R7 overflow after arming
    {OP_DR,  1'b1,1'b0,8'h00,8'h11},
    {OP_SR,  1'b1,1'b0,8'h00,8'h02}, // R7 overflow survives
    {OP_DR,  1'b1,1'b0,8'h00,8'h11},
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R6
    {OP_CW,  1'b1,1'b0,8'h02,8'h00},
    {OP_CR,  1'b1,1'b0,8'h00,8'h02}, // R1
    {OP_IDLE,1'b1,1'b0,8'h00,8'h00},
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R8 no transfer
    {OP_IDLE,1'b0,1'b1,8'h00,8'h00},
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R8 select low
    {OP_IDLE,1'b1,1'b1,8'h00,8'h00},
    {OP_SR,  1'b1,1'b0,8'h00,8'h04}, // R8 fault
    {OP_CW,  1'b1,1'b0,8'h02,8'h00},
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R11 cleared
    {OP_CW,  1'b1,1'b0,8'h03,8'h00},
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R9 select high
    {OP_IDLE,1'b0,1'b0,8'h00,8'h00}, // R9
    {OP_CW,  1'b1,1'b0,8'h01,8'h00}, // R10 R11 unarmed
    {OP_SR,  1'b1,1'b0,8'h00,8'h04}, // R10 kept
    {OP_CW,  1'b1,1'b0,8'h01,8'h00}, // R11
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R11
    {OP_IDLE,1'b0,1'b0,8'h00,8'h00}, // R10 gated
    {OP_SR,  1'b1,1'b0,8'h00,8'h00}, // R10
    {OP_CR,  1'b1,1'b0,8'h00,8'h01}  // R1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, ss_level = 1, xfer_active = 0, rx_done = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, rx_byte = 0, bus_rdata, rx_data;
  logic sck_oe, mosi_oe, miso_oe, rx_full, overflow, mode_fault;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  spi_flag_unit #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_level(ss_level), .xfer_active(xfer_active), .rx_done(rx_done),
    .rx_byte(rx_byte), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
    .rx_full(rx_full), .overflow(overflow), .mode_fault(mode_fault),
    .rx_data(rx_data)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample read data 1ns later, release after rising edge
  task automatic step(input logic [2:0] op, input logic ss, input logic act,
                      input logic [W-1:0] arg, output logic [W-1:0] rd);
    @(negedge clk);
    ss_level = ss; xfer_active = act;
    case (op)
      OP_RX: begin rx_done = 1; rx_byte = arg; end
      OP_SR: begin bus_sel = 1; bus_wr = 0; bus_addr = 2'd0; end
      OP_DR: begin bus_sel = 1; bus_wr = 0; bus_addr = 2'd1; end
      OP_CW: begin bus_sel = 1; bus_wr = 1; bus_addr = 2'd2; bus_wdata = arg; end
      OP_CR: begin bus_sel = 1; bus_wr = 0; bus_addr = 2'd2; end
      default: ;
    endcase
    #1 rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 0; bus_wr = 0; rx_done = 0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R12 miso_oe after reset", W'(miso_oe), 8'h01);
    check("R12 sck_oe after reset", W'(sck_oe), 8'h00);

    for (int i = 0; i < N; i++) begin
      step(VEC[i][20:18], VEC[i][17], VEC[i][16], VEC[i][15:8], rd);
      if (VEC[i][20:18] inside {OP_SR, OP_DR, OP_CR})
        check($sformatf("vector %0d (R1 R3-R12)", i), rd, VEC[i][7:0]);
    end

    // R2 pin directions, currently master with fault checking off
    #1;
    check("R2 master sck_oe", W'(sck_oe), 8'h01);
    check("R2 master mosi_oe", W'(mosi_oe), 8'h01);
    check("R2 master miso_oe", W'(miso_oe), 8'h00);
    step(OP_CW, 1'b1, 1'b0, 8'h00, rd);
    #1;
    check("R2 slave sck_oe", W'(sck_oe), 8'h00);
    check("R2 slave mosi_oe", W'(mosi_oe), 8'h00);
    check("R2 slave miso_oe", W'(miso_oe), 8'h01);

    // R12 reset in the middle of activity
    step(OP_RX, 1'b1, 1'b0, 8'h5A, rd);
    step(OP_RX, 1'b1, 1'b0, 8'h6B, rd);
    step(OP_CW, 1'b1, 1'b0, 8'h03, rd);
    step(OP_IDLE, 1'b0, 1'b0, 8'h00, rd);
    #1;
    check("R9 fault before reset", W'(mode_fault), 8'h01);
    check("R4 data before reset", rx_data, 8'h5A);
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    ss_level = 1;
    check("R12 rx_data", rx_data, 8'h00);
    check("R12 flags", W'({mode_fault, overflow, rx_full}), 8'h00);
    check("R12 slave pins", W'({miso_oe, mosi_oe, sck_oe}), 8'h04);
    step(OP_CR, 1'b1, 1'b0, 8'h00, rd);
    check("R12 control", rd, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule